// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request/acknowledge port and an asynchronous static RAM of 128K words by 8 bits. A client raises a single-word read or write request while the controller is idle; the controller then produces the select, output-enable and write-enable waveforms the RAM needs. It drives the address and, for writes, the outgoing data together with a separate driver-enable for the pad's tri-state buffer. It reports completion with a one-cycle pulse.

Every phase of an access lasts a whole number of clock cycles. Each count is derived at elaboration from the clock period and the RAM's minimum timing figures in nanoseconds: ceiling of the minimum over the period, never less than one cycle. Writes are ended by the write-enable edge with output enable held inactive. The data driver turns on only once the RAM has released the bus. After every read a turnaround gap is inserted, so the RAM's output and the controller's driver never overlap.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, the RAM is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_rd_en_n`=1, `mem_wr_n`=1, `mem_dout_en`=0, `busy`=0 and `done`=0.
- R2: A request (`req`=1) is taken only in a cycle where `busy`=0. `busy` is 1 from the cycle after acceptance until the transfer ends. Requests raised while `busy`=1 have no effect on the pins or on the address.
- R3: A read (`req_we`=0) selects the RAM with `mem_rd_en_n`=0 and `mem_wr_n`=1 for NRD cycles, NRD = max(ceil(T_AA/CLK), ceil(T_DOE/CLK)). `rd_data` takes the bus value sampled at the clock edge that ends the last of those cycles.
- R4: After the read access the RAM is deselected with `mem_rd_en_n`=1 for NTA = ceil(T_HZOE/CLK) cycles before the controller returns to idle.
- R5: A write (`req_we`=1) begins with one cycle in which the RAM is selected, `mem_rd_en_n`=1, `mem_wr_n`=1 and the new address is present.
- R6: `mem_wr_n` is then 0 for NWE cycles, NWE = max(ceil(T_PWE/CLK), NHZ+ceil(T_SD/CLK), ceil(T_AW/CLK)-1, ceil(T_WC/CLK)-2).
- R7: During the low write-enable pulse, `mem_dout_en` is 0 for the first NHZ = ceil(T_HZWE/CLK) cycles and 1 for the rest, with `mem_dout` equal to the request's data.
- R8: One cycle follows the write-enable rise with the RAM still selected and the same data still driven; in the next cycle the driver is off and the RAM deselected.
- R9: `done` is 1 for exactly one cycle, the first idle cycle after each transfer. A request in that cycle is accepted.
- R10: `mem_rd_en_n` is never 0 while `mem_wr_n` is 0 or `mem_dout_en` is 1. `mem_dout_en` never rises within NTA cycles after `mem_rd_en_n` rises.
- R11: `mem_addr` and `mem_dout` stay unchanged from acceptance until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transfer request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data of the request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_rd_en_n | output | 1 | RAM output enable, active low |
| mem_wr_n | output | 1 | RAM write enable, active low |
| mem_dout | output | DATA_W | Data toward the RAM |
| mem_dout_en | output | 1 | Tri-state driver enable for mem_dout |
| mem_din | input | DATA_W | Data from the RAM |

## Verification
Isolated writes and reads to the lowest and highest addresses, with the patterns A5, 5A, FF and 00, fix the length of every phase and show that each data bit and address bit reaches the pins. A stretch in which `req` stays high with changing address, data and direction tells apart requests accepted in the completion cycle from requests that must be ignored while busy, and puts a write directly after a read so the turnaround gap is exercised. A final read-back of every written location, through a RAM model that returns unknown data before the access time has passed, shows whether the capture edge and the write pulse meet the nanosecond minimums.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_RD_TURN  = 3'd2,
      ST_WR_SETUP = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_HOLD  = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic sel_n;
      logic sel;
      logic rd_en_n;
      logic wr_n;
      logic drv;
   } pin_ctl_t;

   localparam pin_ctl_t PIN_IDLE = '{sel_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1, wr_n: 1'b1, drv: 1'b0};

   // whole clock cycles covering a nanosecond minimum, at least one
   function automatic int phase_cycles(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);

   assign cnt_nxt = clear ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

endmodule

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
module sram_access_seq
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W   = 3,
   parameter int C_RD    = 5,
   parameter int C_TA    = 2,
   parameter int C_HZ    = 3,
   parameter int C_WEL   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_we,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic             clear,
   output seq_state_e       state,
   output logic             accept,
   output logic             capture,
   output logic             done,
   output pin_ctl_t         ctl
);

   seq_state_e state_d;

   function automatic pin_ctl_t decode(input seq_state_e st, input logic [CNT_W-1:0] c);
      pin_ctl_t p;
      p = PIN_IDLE;
      case (st)
         ST_RD_ACC: begin
            p.sel_n   = 1'b0;
            p.sel     = 1'b1;
            p.rd_en_n = 1'b0;
         end
         ST_WR_SETUP: begin
            p.sel_n = 1'b0;
            p.sel   = 1'b1;
         end
         ST_WR_PULSE: begin
            p.sel_n = 1'b0;
            p.sel   = 1'b1;
            p.wr_n  = 1'b0;
            p.drv   = (c >= CNT_W'(C_HZ));
         end
         ST_WR_HOLD: begin
            p.sel_n = 1'b0;
            p.sel   = 1'b1;
            p.drv   = 1'b1;
         end
         default: p = PIN_IDLE;
      endcase
      return p;
   endfunction

   always_comb begin
      state_d = state;
      case (state)
         ST_IDLE:     if (req) state_d = req_we ? ST_WR_SETUP : ST_RD_ACC;
         ST_RD_ACC:   if (cnt == CNT_W'(C_RD - 1)) state_d = ST_RD_TURN;
         ST_RD_TURN:  if (cnt == CNT_W'(C_TA - 1)) state_d = ST_IDLE;
         ST_WR_SETUP: state_d = ST_WR_PULSE;
         ST_WR_PULSE: if (cnt == CNT_W'(C_WEL - 1)) state_d = ST_WR_HOLD;
         ST_WR_HOLD:  state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign clear   = (state_d != state);
   assign accept  = (state == ST_IDLE) && req;
   assign capture = (state == ST_RD_ACC) && (cnt == CNT_W'(C_RD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_d;
         done  <= (state != ST_IDLE) && (state_d == ST_IDLE);
      end
   end

   generate
      if (OUT_REG) begin : g_pins_reg
         pin_ctl_t ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl_q <= PIN_IDLE;
            else        ctl_q <= decode(state_d, cnt_nxt);
         end
         assign ctl = ctl_q;
      end else begin : g_pins_comb
         assign ctl = decode(state, cnt);
      end
   endgenerate

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_din,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dout <= '0;
         rd_data  <= '0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
         end
         if (capture) rd_data <= mem_din;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 4,
   parameter int T_AA_NS   = 20,
   parameter int T_DOE_NS  = 9,
   parameter int T_HZOE_NS = 7,
   parameter int T_HZWE_NS = 10,
   parameter int T_PWE_NS  = 12,
   parameter int T_AW_NS   = 15,
   parameter int T_SD_NS   = 10,
   parameter int T_WC_NS   = 20,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_rd_en_n,
   output logic              mem_wr_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);

   localparam int C_RD  = max_of(phase_cycles(T_AA_NS, CLK_NS), phase_cycles(T_DOE_NS, CLK_NS));
   localparam int C_TA  = phase_cycles(T_HZOE_NS, CLK_NS);
   localparam int C_HZ  = phase_cycles(T_HZWE_NS, CLK_NS);
   localparam int C_SD  = phase_cycles(T_SD_NS, CLK_NS);
   localparam int C_WEL = max_of(max_of(phase_cycles(T_PWE_NS, CLK_NS), C_HZ + C_SD),
                                 max_of(phase_cycles(T_AW_NS, CLK_NS) - 1,
                                        phase_cycles(T_WC_NS, CLK_NS) - 2));
   localparam int C_MAX = max_of(max_of(C_RD, C_TA), C_WEL);
   localparam int CNT_W = $clog2(C_MAX + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (C_WEL <= C_HZ) begin : g_bad_pulse
         $error("write pulse leaves no data setup window");
      end
   endgenerate

   logic             clear;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   seq_state_e       state;
   logic             accept;
   logic             capture;
   pin_ctl_t         ctl;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt)
   );

   sram_access_seq #(
      .CNT_W   (CNT_W),
      .C_RD    (C_RD),
      .C_TA    (C_TA),
      .C_HZ    (C_HZ),
      .C_WEL   (C_WEL),
      .OUT_REG (OUT_REG)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_we  (req_we),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .clear   (clear),
      .state   (state),
      .accept  (accept),
      .capture (capture),
      .done    (done),
      .ctl     (ctl)
   );

   sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_din   (mem_din),
      .mem_addr  (mem_addr),
      .mem_dout  (mem_dout),
      .rd_data   (rd_data)
   );

   assign busy        = (state != ST_IDLE);
   assign mem_sel_n   = ctl.sel_n;
   assign mem_sel     = ctl.sel;
   assign mem_rd_en_n = ctl.rd_en_n;
   assign mem_wr_n    = ctl.wr_n;
   assign mem_dout_en = ctl.drv;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 4,
   parameter int T_HZOE_NS = 7,
   parameter int T_HZWE_NS = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_rd_en_n,
   input logic              mem_wr_n,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dout_en
);

   localparam int K_TA = phase_cycles(T_HZOE_NS, CLK_NS);
   localparam int K_HZ = phase_cycles(T_HZWE_NS, CLK_NS);

   logic [7:0] wl_run;   // cycles write enable has been low
   logic [7:0] oe_off;   // cycles since output enable went high

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wl_run <= '0;
         oe_off <= 8'hFF;
      end else begin
         if (mem_wr_n)            wl_run <= '0;
         else if (wl_run != 8'hFF) wl_run <= wl_run + 1'b1;
         if (!mem_rd_en_n)        oe_off <= '0;
         else if (oe_off != 8'hFF) oe_off <= oe_off + 1'b1;
      end
   end

   assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_n && !mem_dout_en));

   assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_no_read_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n || mem_dout_en) |-> mem_rd_en_n);

   assert_release_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dout_en) |-> (!mem_wr_n && (32'(wl_run) >= K_HZ)));

   assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dout_en) |-> (32'(oe_off) >= K_TA));

   assert_hold_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (mem_dout_en && !mem_sel_n && mem_sel && $stable(mem_dout)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CLK_NS    (CLK_NS),
   .T_HZOE_NS (T_HZOE_NS),
   .T_HZWE_NS (T_HZWE_NS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .mem_addr    (mem_addr),
   .mem_sel_n   (mem_sel_n),
   .mem_sel     (mem_sel),
   .mem_rd_en_n (mem_rd_en_n),
   .mem_wr_n    (mem_wr_n),
   .mem_dout    (mem_dout),
   .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

   localparam int AW = 17, DW = 8, CLK = 4;
   localparam int TAA = 20, TDOE = 9, THZOE = 7, THZWE = 10;
   localparam int TPWE = 12, TAW = 15, TSD = 10, TWC = 20;

   function automatic int up(input int ns);
      int q;
      q = ns / CLK;
      if (q * CLK < ns) q++;
      if (q == 0) q = 1;
      return q;
   endfunction

   function automatic int wel();
      int v;
      v = up(TPWE);
      if (up(THZWE) + up(TSD) > v) v = up(THZWE) + up(TSD);
      if (up(TAW) - 1 > v) v = up(TAW) - 1;
      if (up(TWC) - 2 > v) v = up(TWC) - 2;
      return v;
   endfunction

   localparam int B_RD  = (up(TAA) > up(TDOE)) ? up(TAA) : up(TDOE);
   localparam int B_TA  = up(THZOE);
   localparam int B_HZ  = up(THZWE);
   localparam int B_WEL = wel();

   logic          clk, rst_n, req, req_we;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          busy, done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_n, mem_dout_en;
   logic [DW-1:0] mem_dout, mem_din;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_AA_NS(TAA), .T_DOE_NS(TDOE),
      .T_HZOE_NS(THZOE), .T_HZWE_NS(THZWE), .T_PWE_NS(TPWE), .T_AW_NS(TAW),
      .T_SD_NS(TSD), .T_WC_NS(TWC), .OUT_REG(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
      .mem_rd_en_n(mem_rd_en_n), .mem_wr_n(mem_wr_n), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit            m_act = 0, m_rd = 0;
   int            m_t = 0, m_len = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wd = '0, m_rdata = '0;
   logic [DW-1:0] store [int];

   // behavioural RAM state
   logic [DW-1:0] ram [int];
   int            ram_rc = 0, ram_wl = 0, ram_sd = 0, ram_tail = 0;
   logic [AW-1:0] ram_pa = '0;
   logic [DW-1:0] ram_pd = '0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic  e_done, e_seln, e_sel, e_oen, e_wrn, e_drv;
      string ph;
      @(negedge clk);
      e_done = 1'b0;
      if (m_act && m_t == m_len) begin
         m_act  = 0;
         e_done = 1'b1;
      end
      e_seln = 1; e_sel = 0; e_oen = 1; e_wrn = 1; e_drv = 0; ph = "R1";
      if (m_act && m_rd) begin
         if (m_t < B_RD) begin e_seln = 0; e_sel = 1; e_oen = 0; ph = "R3"; end
         else ph = "R4";
      end else if (m_act) begin
         e_seln = 0; e_sel = 1;
         if (m_t == 0) ph = "R5";
         else if (m_t <= B_WEL) begin
            e_wrn = 0; e_drv = ((m_t - 1) >= B_HZ); ph = "R6";
         end else begin
            e_drv = 1; ph = "R8";
         end
      end
      chk(busy === logic'(m_act), "R2", "busy", 32'(busy), 32'(m_act));
      chk(done === e_done, "R9", "done", 32'(done), 32'(e_done));
      chk(mem_sel_n === e_seln, ph, "sel_n", 32'(mem_sel_n), 32'(e_seln));
      chk(mem_sel === e_sel, ph, "sel", 32'(mem_sel), 32'(e_sel));
      chk(mem_rd_en_n === e_oen, ph, "rd_en_n", 32'(mem_rd_en_n), 32'(e_oen));
      chk(mem_wr_n === e_wrn, ph, "wr_n", 32'(mem_wr_n), 32'(e_wrn));
      chk(mem_dout_en === e_drv, (ph == "R6") ? "R7" : ph, "dout_en", 32'(mem_dout_en), 32'(e_drv));
      chk(mem_addr === m_addr, "R11", "addr", 32'(mem_addr), 32'(m_addr));
      if (e_drv) chk(mem_dout === m_wd, "R7", "dout", 32'(mem_dout), 32'(m_wd));
      chk(rd_data === m_rdata, "R3", "rd_data", 32'(rd_data), 32'(m_rdata));

      // RAM model: bus contention, read access time, write pulse timing
      if (mem_dout_en && (ram_tail > 0 || (!mem_sel_n && mem_sel && !mem_rd_en_n)))
         chk(1'b0, "R10", "bus contention", 32'(mem_dout_en), 32'h0);
      if (!mem_sel_n && mem_sel && !mem_rd_en_n && mem_wr_n) begin
         if (mem_addr !== ram_pa) ram_rc = 0;
         ram_rc++;
         ram_tail = B_TA;
         if (ram_rc * CLK >= TAA && ram_rc * CLK >= TDOE && ram.exists(int'(mem_addr)))
            mem_din = ram[int'(mem_addr)];
         else
            mem_din = 'x;
      end else begin
         ram_rc = 0;
         if (ram_tail > 0) ram_tail--;
         mem_din = 'x;
      end
      if (!mem_sel_n && mem_sel && !mem_wr_n) begin
         ram_wl++;
         if (mem_dout_en) begin
            if (ram_sd > 0 && mem_dout === ram_pd) ram_sd++;
            else ram_sd = 1;
            ram_pd = mem_dout;
         end else ram_sd = 0;
      end else if (ram_wl > 0) begin
         chk(ram_wl * CLK >= TPWE, "R6", "write pulse ns", 32'(ram_wl * CLK), 32'(TPWE));
         chk((ram_wl + 1) * CLK >= TAW, "R5", "address to write end ns", 32'((ram_wl + 1) * CLK), 32'(TAW));
         chk(ram_sd * CLK >= TSD, "R7", "data setup ns", 32'(ram_sd * CLK), 32'(TSD));
         chk(mem_dout_en === 1'b1 && mem_dout === ram_pd, "R8", "data hold", 32'(mem_dout), 32'(ram_pd));
         ram[int'(mem_addr)] = mem_dout;
         ram_wl = 0;
         ram_sd = 0;
      end
      ram_pa = mem_addr;

      // stimulus for this cycle and model advance
      req = r; req_we = w; req_addr = a; req_wdata = d;
      if (!m_act && r) begin
         m_act  = 1; m_t = 0; m_rd = !w; m_addr = a;
         m_len  = w ? (B_WEL + 2) : (B_RD + B_TA);
         if (w) begin m_wd = d; store[int'(a)] = d; end
      end else if (m_act) begin
         if (m_rd && m_t == B_RD - 1) m_rdata = store[int'(m_addr)];
         m_t++;
      end
   endtask

   task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(1'b1, w, a, d);
      while (m_act) step(1'b0, 1'b0, '0, '0);
   endtask

   initial begin
      rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; mem_din = 'x;
      repeat (3) @(negedge clk);
      chk(mem_sel_n === 1'b1 && mem_sel === 1'b0, "R1", "reset select", 32'({mem_sel_n, mem_sel}), 32'h2);
      chk(mem_rd_en_n === 1'b1 && mem_wr_n === 1'b1 && mem_dout_en === 1'b0, "R1", "reset strobes",
          32'({mem_rd_en_n, mem_wr_n, mem_dout_en}), 32'h6);
      chk(busy === 1'b0 && done === 1'b0, "R1", "reset status", 32'({busy, done}), 32'h0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, '0, '0);

      // R5 R6 R7 R8: isolated writes, corner addresses, bit patterns
      issue(1'b1, 17'h00000, 8'hA5);
      issue(1'b1, 17'h1FFFF, 8'h5A);
      issue(1'b1, 17'h00155, 8'hFF);
      issue(1'b1, 17'h0AAAA, 8'h00);
      // R3 R4: isolated reads
      issue(1'b0, 17'h00000, '0);
      issue(1'b0, 17'h1FFFF, '0);
      issue(1'b0, 17'h00155, '0);
      issue(1'b0, 17'h0AAAA, '0);

      // R2 R9 R10: request held high; ignored while busy, taken in the done cycle
      for (int i = 0; i < 60; i++) begin
         logic wr;
         wr = (i % 3) != 0;
         step(1'b1, wr, wr ? 17'(i * 977 + 3) : 17'h1FFFF, 8'(i * 37 + 1));
      end
      while (m_act) step(1'b0, 1'b0, '0, '0);

      // read back every written location
      foreach (store[k]) issue(1'b0, 17'(k), '0);
      repeat (4) step(1'b0, 1'b0, '0, '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule